// File: doc/BRIEF.md
# Decoded I/O Port Interface

This block attaches to a multiplexed processor bus and provides two ports: an output port that keeps a byte for a bank of LEDs, and an input port that places the state of eight switches on the shared data bus. In its default form the ports live in peripheral I/O space. Selection compares only the upper address byte against a port number, and is qualified by the I/O-versus-memory line and the active-low read or write strobe. The input and output port spaces are independent, so one port number may name one device for reads and a different device for writes.

The output byte is taken from the data bus on the rising edge of the write strobe, using the data present in the last clock cycle the strobe was low and selected. It is then held until the next selected write. The LED lines are the inverse of the held byte, so a 1 written on the bus drives its LED cathode low and lights it. The input side has no storage. While the read strobe is low and the port is selected, a drive enable rises in the same cycle and the switch byte appears on the data output. At all other times the enable is low, which stands for high impedance, and the data output is zero. A parameter switches the block to memory-mapped operation. In that mode the whole 16-bit address is compared and the memory qualifier (I/O line low) replaces the I/O qualifier.

Top module: `busPortUnit`

## Requirements
- R1: After reset the held output byte is 00h, so every bit of `ledN` is 1 (all LEDs off).
- R2: A write is selected in a cycle where `wrN` is 0, `ioMem` is 1 and `busAddr[15:8]` equals FFh. In the first cycle `wrN` is 1 after a selected low cycle, the byte on `busData` in that last low cycle is loaded. `ledN` shows its bitwise inverse from the next clock edge on.
- R3: A write with `ioMem` equal to 0 never changes `ledN` in I/O mode.
- R4: A write whose upper address byte differs from FFh does not change `ledN`.
- R5: Whenever `rdN` is 0, `ioMem` is 1 and `busAddr[15:8]` equals 0Fh, `dataOutEn` is 1 and `dataOut` equals `switches` in the same cycle, with no clock delay.
- R6: When the read selection of R5 is not met, `dataOutEn` is 0 and `dataOut` is 00h.
- R7: The port spaces are separate: a read at upper byte FFh does not drive the bus, and a write at upper byte 0Fh does not load the LED byte.
- R8: With no selected write, `ledN` keeps its value for any number of cycles, including while reads take place.
- R9: With `MEM_MAPPED` = 1, writes and reads require `ioMem` = 0 and a full 16-bit address match, against `OUT_MEM_ADDR` (default 40FFh) and `IN_MEM_ADDR` (default 400Fh). A partial match or `ioMem` = 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Bus address, upper byte carries the port number |
| busData | input | 8 | Data on the bus during a write |
| ioMem | input | 1 | 1 for I/O cycles, 0 for memory cycles |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| switches | input | 8 | Switch levels for the input port |
| dataOut | output | 8 | Byte driven toward the data bus, zero when idle |
| dataOutEn | output | 1 | Drive enable for the data bus, low means released |
| ledN | output | 8 | Inverted held byte, low lights an LED |

## Verification
A held-byte load and a bus drive can happen in the same cycle. This occurs when the write strobe rises from a selected output write while the address already points at the input port with the read strobe low. The bench builds exactly that cycle and expects both effects: the enable and switch byte at once, and the LED lines updated at the following edge. A behavioural model tracks the pending write and the held byte on every clock, for both the I/O-mapped and the memory-mapped instance.

// File: rtl/busPortPkg.sv
package busPortPkg;
  typedef struct packed {
    logic captureData;
    logic loadLatch;
    logic driveBus;
  } portStrobes_t;
endpackage

// File: rtl/portControl.sv
module portControl
  import busPortPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter bit MEM_MAPPED = 1'b0,
  parameter logic [PORT_W-1:0] OUT_PORT = 8'hFF,
  parameter logic [PORT_W-1:0] IN_PORT = 8'h0F,
  parameter logic [ADDR_W-1:0] OUT_MEM_ADDR = 16'h40FF,
  parameter logic [ADDR_W-1:0] IN_MEM_ADDR = 16'h400F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ioMem,
  input  logic              rdN,
  input  logic              wrN,
  output portStrobes_t      strobes
);
  localparam int HI_LSB = ADDR_W - PORT_W;

  logic spaceOk;
  logic outHit;
  logic inHit;
  logic wrSel;
  logic armed;

  generate
    if (MEM_MAPPED) begin : g_memDecode
      assign spaceOk = !ioMem;
      assign outHit  = (addr == OUT_MEM_ADDR);
      assign inHit   = (addr == IN_MEM_ADDR);
    end else begin : g_ioDecode
      logic unusedAddrLow;
      assign unusedAddrLow = ^addr[HI_LSB-1:0];
      assign spaceOk = ioMem;
      assign outHit  = (addr[ADDR_W-1:HI_LSB] == OUT_PORT);
      assign inHit   = (addr[ADDR_W-1:HI_LSB] == IN_PORT);
    end
  endgenerate

  assign wrSel = !wrN && spaceOk && outHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= wrSel;
  end

  always_comb begin
    strobes.captureData = wrSel;
    strobes.loadLatch   = armed && wrN;
    strobes.driveBus    = !rdN && spaceOk && inHit;
  end
endmodule

// File: rtl/portDatapath.sv
module portDatapath
  import busPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] switchIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOutEn,
  output logic [DATA_W-1:0] ledN
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] latchReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    holdReg <= '0;
    else if (strobes.captureData) holdReg <= busIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  latchReg <= '0;
    else if (strobes.loadLatch) latchReg <= holdReg;
  end

  assign ledN     = ~latchReg;
  assign busOutEn = strobes.driveBus;
  assign busOut   = strobes.driveBus ? switchIn : '0;
endmodule

// File: rtl/busPortUnit.sv
module busPortUnit
  import busPortPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PORT_W = 8,
  parameter bit MEM_MAPPED = 1'b0,
  parameter logic [PORT_W-1:0] OUT_PORT = 8'hFF,
  parameter logic [PORT_W-1:0] IN_PORT = 8'h0F,
  parameter logic [ADDR_W-1:0] OUT_MEM_ADDR = 16'h40FF,
  parameter logic [ADDR_W-1:0] IN_MEM_ADDR = 16'h400F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              ioMem,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] switches,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic [DATA_W-1:0] ledN
);
  portStrobes_t strobes;

  portControl #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .MEM_MAPPED(MEM_MAPPED),
    .OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT),
    .OUT_MEM_ADDR(OUT_MEM_ADDR), .IN_MEM_ADDR(IN_MEM_ADDR)
  ) u_control (
    .clk(clk), .rstN(rstN), .addr(busAddr), .ioMem(ioMem),
    .rdN(rdN), .wrN(wrN), .strobes(strobes)
  );

  portDatapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busIn(busData),
    .switchIn(switches), .busOut(dataOut), .busOutEn(dataOutEn), .ledN(ledN)
  );
endmodule

// File: rtl/busPortChecker.sv
module busPortChecker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PORT_W = 8,
  parameter bit MEM_MAPPED = 1'b0,
  parameter logic [PORT_W-1:0] OUT_PORT = 8'hFF,
  parameter logic [PORT_W-1:0] IN_PORT = 8'h0F,
  parameter logic [ADDR_W-1:0] OUT_MEM_ADDR = 16'h40FF,
  parameter logic [ADDR_W-1:0] IN_MEM_ADDR = 16'h400F
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              ioMem,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] switches,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic [DATA_W-1:0] ledN
);
  localparam int HI_LSB = ADDR_W - PORT_W;

  logic spaceOk, outHit, inHit, wrSel, rdSel, primed;
  logic [1:0] aliveCnt;

  generate
    if (MEM_MAPPED) begin : g_memSpace
      assign spaceOk = !ioMem;
      assign outHit  = (busAddr == OUT_MEM_ADDR);
      assign inHit   = (busAddr == IN_MEM_ADDR);
    end else begin : g_ioSpace
      logic unusedLowBits;
      assign unusedLowBits = ^busAddr[HI_LSB-1:0];
      assign spaceOk = ioMem;
      assign outHit  = (busAddr[ADDR_W-1:HI_LSB] == OUT_PORT);
      assign inHit   = (busAddr[ADDR_W-1:HI_LSB] == IN_PORT);
    end
  endgenerate

  assign wrSel = !wrN && spaceOk && outHit;
  assign rdSel = !rdN && spaceOk && inHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              aliveCnt <= '0;
    else if (aliveCnt != 2'd3) aliveCnt <= aliveCnt + 2'd1;
  end
  assign primed = (aliveCnt >= 2'd2);

  p_reset_leds_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ledN == '1));

  p_load_last_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(wrSel) && wrN) |=> (ledN == ~$past(busData, 2)));

  // also covers R4, R7 and R8: no selected write, no change
  p_ignore_other_writes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && wrN && !$past(wrSel)) |=> $stable(ledN));

  p_drive_only_selected_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (rdSel && dataOut == switches));

  p_drive_on_select_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> dataOutEn);

  p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == '0));
endmodule

bind busPortUnit busPortChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .MEM_MAPPED(MEM_MAPPED),
  .OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT),
  .OUT_MEM_ADDR(OUT_MEM_ADDR), .IN_MEM_ADDR(IN_MEM_ADDR)
) u_busPortChecker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
  .ioMem(ioMem), .rdN(rdN), .wrN(wrN), .switches(switches),
  .dataOut(dataOut), .dataOutEn(dataOutEn), .ledN(ledN)
);

// File: tb/test_busPortUnit.sv
`timescale 1ns/1ps
module test_busPortUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic        ioMem = 1'b0;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [7:0]  switches = '0;
  logic [7:0]  dataOut, dataOutM, ledN, ledNM;
  logic        dataOutEn, dataOutEnM;

  int testCnt = 0;
  int failCnt = 0;

  // behavioural reference state
  bit       pendIo = 0, pendMem = 0;
  bit [7:0] holdIo = 0, holdMem = 0, keptIo = 0, keptMem = 0;

  always #4 clk = ~clk;

  busPortUnit i_busPortUnit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .ioMem(ioMem), .rdN(rdN), .wrN(wrN), .switches(switches),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .ledN(ledN));

  busPortUnit #(.MEM_MAPPED(1'b1), .OUT_MEM_ADDR(16'h40FF), .IN_MEM_ADDR(16'h400F))
  i_busPortUnitMem (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .ioMem(ioMem), .rdN(rdN), .wrN(wrN), .switches(switches),
    .dataOut(dataOutM), .dataOutEn(dataOutEnM), .ledN(ledNM));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  // one bus cycle: drive after a falling edge, check both instances
  task automatic tick(input string tag, input logic [15:0] a, input logic [7:0] d,
                      input logic io, input logic rd, input logic wr,
                      input logic [7:0] sw);
    bit       rdIo, rdMem;
    logic [7:0] expIo, expMem;
    busAddr = a; busData = d; ioMem = io; rdN = rd; wrN = wr; switches = sw;
    #1;
    rdIo  = !rd && io && (a[15:8] == 8'h0F);
    rdMem = !rd && !io && (a == 16'h400F);
    expIo  = rdIo ? sw : 8'h00;
    expMem = rdMem ? sw : 8'h00;
    chk(dataOutEn == rdIo, tag, "io enable", {15'd0, dataOutEn}, {15'd0, rdIo});
    chk(dataOut == expIo, tag, "io data", {8'd0, dataOut}, {8'd0, expIo});
    chk(dataOutEnM == rdMem, tag, "mem enable", {15'd0, dataOutEnM}, {15'd0, rdMem});
    chk(dataOutM == expMem, tag, "mem data", {8'd0, dataOutM}, {8'd0, expMem});
    @(posedge clk);
    if (pendIo && wr) keptIo = holdIo;
    pendIo = !wr && io && (a[15:8] == 8'hFF);
    if (pendIo) holdIo = d;
    if (pendMem && wr) keptMem = holdMem;
    pendMem = !wr && !io && (a == 16'h40FF);
    if (pendMem) holdMem = d;
    #1;
    chk(ledN == ~keptIo, tag, "io leds", {8'd0, ledN}, {8'd0, ~keptIo});
    chk(ledNM == ~keptMem, tag, "mem leds", {8'd0, ledNM}, {8'd0, ~keptMem});
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ledN == 8'hFF, "R1", "leds in reset", {8'd0, ledN}, 16'h00FF);
    rstN = 1'b1;
    tick("R1", 16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00);
    chk(ledN == 8'hFF && ledNM == 8'hFF, "R1", "leds after reset",
        {ledNM, ledN}, 16'hFFFF);

    // R2: selected write, load on strobe rise
    tick("R2", 16'hFF12, 8'hA5, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R2", 16'hFF12, 8'hA5, 1'b1, 1'b1, 1'b1, 8'h00);
    chk(ledN == 8'h5A, "R2", "inverted byte", {8'd0, ledN}, 16'h005A);
    // R2: long low strobe with changing data, last value wins
    tick("R2", 16'hFF00, 8'h11, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R2", 16'hFF00, 8'h22, 1'b1, 1'b1, 1'b0, 8'h00);
    chk(ledN == 8'h5A, "R2", "no load while low", {8'd0, ledN}, 16'h005A);
    tick("R2", 16'hFF00, 8'h81, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R2", 16'hFF00, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00);
    chk(ledN == 8'h7E, "R2", "last low data", {8'd0, ledN}, 16'h007E);

    // R3: memory write at the same upper byte
    tick("R3", 16'hFF34, 8'h3C, 1'b0, 1'b1, 1'b0, 8'h00);
    tick("R3", 16'hFF34, 8'h3C, 1'b0, 1'b1, 1'b1, 8'h00);
    chk(ledN == 8'h7E, "R3", "memory write ignored", {8'd0, ledN}, 16'h007E);
    // R4: other port number
    tick("R4", 16'h7EFF, 8'hC3, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R4", 16'h7EFF, 8'hC3, 1'b1, 1'b1, 1'b1, 8'h00);
    chk(ledN == 8'h7E, "R4", "other port ignored", {8'd0, ledN}, 16'h007E);
    // R7: write to the input port number
    tick("R7", 16'h0FFF, 8'hF0, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R7", 16'h0FFF, 8'hF0, 1'b1, 1'b1, 1'b1, 8'h00);
    chk(ledN == 8'h7E, "R7", "write at input number", {8'd0, ledN}, 16'h007E);

    // R5: read of the switch port
    tick("R5", 16'h0F34, 8'h00, 1'b1, 1'b0, 1'b1, 8'h5A);
    tick("R5", 16'h0F0F, 8'h00, 1'b1, 1'b0, 1'b1, 8'hC7);
    // R7: read at output port number, R6: memory read, idle read strobe
    tick("R7", 16'hFF0F, 8'h00, 1'b1, 1'b0, 1'b1, 8'h5A);
    tick("R6", 16'h0F00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A);
    tick("R6", 16'h0F00, 8'h00, 1'b1, 1'b1, 1'b1, 8'hFF);

    // R8: hold across idle cycles and reads
    for (int i = 0; i < 6; i++)
      tick("R8", 16'h0F00, 8'h99, 1'b1, (i % 2 == 0), 1'b1, 8'(i * 37));
    chk(ledN == 8'h7E, "R8", "held value", {8'd0, ledN}, 16'h007E);

    // concurrency: strobe rise into an input-port read
    tick("R2", 16'hFF00, 8'h0C, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R5", 16'h0F00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3E);
    chk(ledN == 8'hF3, "R2", "load during read", {8'd0, ledN}, 16'h00F3);

    // R9: memory-mapped instance
    tick("R9", 16'h40FF, 8'h81, 1'b0, 1'b1, 1'b0, 8'h00);
    tick("R9", 16'h40FF, 8'h81, 1'b0, 1'b1, 1'b1, 8'h00);
    chk(ledNM == 8'h7E, "R9", "mem write loads", {8'd0, ledNM}, 16'h007E);
    chk(ledN == 8'hF3, "R9", "io unit unaffected", {8'd0, ledN}, 16'h00F3);
    tick("R9", 16'h41FF, 8'h0F, 1'b0, 1'b1, 1'b0, 8'h00);
    tick("R9", 16'h41FF, 8'h0F, 1'b0, 1'b1, 1'b1, 8'h00);
    tick("R9", 16'h40FF, 8'h0F, 1'b1, 1'b1, 1'b0, 8'h00);
    tick("R9", 16'h40FF, 8'h0F, 1'b1, 1'b1, 1'b1, 8'h00);
    chk(ledNM == 8'h7E, "R9", "partial match ignored", {8'd0, ledNM}, 16'h007E);
    tick("R9", 16'h400F, 8'h00, 1'b0, 1'b0, 1'b1, 8'hB4);
    tick("R9", 16'h410F, 8'h00, 1'b0, 1'b0, 1'b1, 8'hB4);
    tick("R9", 16'h400F, 8'h00, 1'b1, 1'b0, 1'b1, 8'hB4);
    tick("R9", 16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00);

    finishRun();
  end
endmodule